// File: doc/BRIEF.md
# Binary Tree Up-Down Router

This block plans routes through a binary tree whose leaves carry `ADDR_W`-bit addresses. It takes a source leaf and a destination leaf. From these it finds how many levels a packet must climb to reach the lowest node that the two leaves share. It also finds the left/right choices the packet takes on the way back down. The climb height is one more than the index of the highest bit where the two addresses disagree. The descent choices are the low bits of the destination, used from the most significant of them to the least.

A request is offered on a valid/ready channel together with a mode bit. In plan mode, the block returns one output beat that holds the climb height, the total hop count and the masked descent vector. In step mode, it returns one beat per hop: first the "up" beats, then one left/right beat per level of the descent, with the final beat flagged. The output channel is also valid/ready, so a slow consumer can pace the stepper one hop at a time. Only one request is in flight at any time.

Top module: `tree_route_unit`

## Requirements
- R1: While `rst_ni` is low and right after reset, `req_ready_o` is 1 and `out_valid_o` is 0.
- R2: `out_climb_o` equals one plus the index of the highest set bit of `req_src_i ^ req_dst_i`. It is 0 when the two addresses are equal.
- R3: `out_hops_o` equals twice `out_climb_o`.
- R4: `out_path_o` carries bits `[climb-1:0]` of the destination in place, and every bit at or above position `climb` is 0.
- R5: A step-mode request with climb C > 0 first produces exactly C beats with `out_up_o`=1. Each of these beats moves the packet to the parent node.
- R6: The up beats are followed by exactly C beats with `out_up_o`=0. Their `out_right_o` values are destination bits C-1 down to 0, where 1 selects the right child and 0 the left child. `out_last_o` is 1 on the final beat only. The walk ends at the destination leaf and never climbs above the common ancestor.
- R7: A step-mode request with equal addresses produces no output beat, and `req_ready_o` is 1 again on the next cycle.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, the beat's fields hold steady into the next cycle.
- R9: `req_ready_o` is 0 while any beat of the current request is still pending. It returns to 1 right after the final beat is taken.
- R10: A plan-mode request yields exactly one beat with `out_plan_o`=1 and `out_up_o`, `out_right_o`, `out_last_o` all 0. Step beats have `out_plan_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_src_i | input | ADDR_W | Source leaf address |
| req_dst_i | input | ADDR_W | Destination leaf address |
| req_step_i | input | 1 | 0: plan mode, 1: step mode |
| out_valid_o | output | 1 | Output beat present |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_plan_o | output | 1 | Beat is a whole-route plan |
| out_climb_o | output | $clog2(ADDR_W+1) | Levels to climb |
| out_hops_o | output | $clog2(ADDR_W+1)+1 | Total hops, up plus down |
| out_path_o | output | ADDR_W | Descent bits, masked to the climb height |
| out_up_o | output | 1 | Step beat: go to parent |
| out_right_o | output | 1 | Step beat: descend to right child (0 = left) |
| out_last_o | output | 1 | Final step beat of the route |

## Verification
A wrong climb height shows at the ports one cycle after the request is accepted. In plan mode it appears directly as a bad climb, hop or path value. In step mode it appears as the wrong number of up beats, which makes the software tree walk end on the wrong leaf or rise past the common ancestor. A bad step counter or state register shows at the next beat as a misplaced last flag, an up beat after a down beat, or a request port that reopens too early or too late. A beat that changes while it is stalled is caught on the cycle after the change.

// File: rtl/tre_pkg.sv
package tre_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PLAN = 2'd1,
    SEQ_UP   = 2'd2,
    SEQ_DOWN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tre_lead_one.sv
module tre_lead_one #(
  parameter int W   = 6,
  localparam int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o   // index of top set bit plus one, 0 if none
);
  logic [W:0]   clear_above;
  logic [W-1:0] first_hot;

  assign clear_above[W] = 1'b1;
  for (genvar g = W - 1; g >= 0; g--) begin : g_scan
    assign clear_above[g] = clear_above[g+1] & ~vec_i[g];
    assign first_hot[g]   = vec_i[g] & clear_above[g+1];
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first_hot[i]) pos_o = pos_o | PW'(i + 1);
    end
  end
endmodule

// File: rtl/tre_planner.sv
module tre_planner #(
  parameter int ADDR_W = 6,
  localparam int LW    = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic [LW-1:0]     climb_o,
  output logic [ADDR_W-1:0] path_o
);
  logic [ADDR_W-1:0] diff;
  assign diff = src_i ^ dst_i;

  tre_lead_one #(.W(ADDR_W)) u_lead (
    .vec_i (diff),
    .pos_o (climb_o)
  );

  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign path_o[g] = dst_i[g] & (LW'(g) < climb_o);
  end

  always_comb begin
    // R2
    climb_msb_chk: assert ((diff == '0) ? (climb_o == '0)
                           : ((diff >> (climb_o - LW'(1))) == ADDR_W'(1)));
  end
endmodule

// File: rtl/tre_sequencer.sv
module tre_sequencer
  import tre_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int LW    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_step_i,
  input  logic [LW-1:0]     climb_i,
  input  logic [ADDR_W-1:0] path_i,
  output logic              req_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_plan_o,
  output logic [LW-1:0]     out_climb_o,
  output logic [LW:0]       out_hops_o,
  output logic [ADDR_W-1:0] out_path_o,
  output logic              out_up_o,
  output logic              out_right_o,
  output logic              out_last_o
);
  seq_state_e        state_q;
  logic [LW-1:0]     climb_q, cnt_q;
  logic [ADDR_W-1:0] path_q;
  logic              accept, take, cnt_one;

  assign accept  = req_valid_i & req_ready_o;
  assign take    = out_valid_o & out_ready_i;
  assign cnt_one = (cnt_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      climb_q <= '0;
      cnt_q   <= '0;
      path_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          climb_q <= climb_i;
          path_q  <= path_i;
          cnt_q   <= climb_i;
          if (!req_step_i)          state_q <= SEQ_PLAN;
          else if (climb_i != '0)   state_q <= SEQ_UP;
        end
        SEQ_PLAN: if (take) state_q <= SEQ_IDLE;
        SEQ_UP: if (take) begin
          if (cnt_one) begin
            state_q <= SEQ_DOWN;
            cnt_q   <= climb_q;
          end else begin
            cnt_q <= cnt_q - LW'(1);
          end
        end
        SEQ_DOWN: if (take) begin
          if (cnt_one) state_q <= SEQ_IDLE;
          else         cnt_q   <= cnt_q - LW'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  logic [ADDR_W-1:0] path_sh;
  assign path_sh = path_q >> (cnt_q - LW'(1));

  assign req_ready_o = (state_q == SEQ_IDLE);
  assign out_valid_o = (state_q != SEQ_IDLE);
  assign out_plan_o  = (state_q == SEQ_PLAN);
  assign out_climb_o = climb_q;
  assign out_hops_o  = {climb_q, 1'b0};
  assign out_path_o  = path_q;
  assign out_up_o    = (state_q == SEQ_UP);
  assign out_right_o = (state_q == SEQ_DOWN) & path_sh[0];
  assign out_last_o  = (state_q == SEQ_DOWN) & cnt_one;

  // R8
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_plan_o, out_up_o, out_right_o, out_last_o, out_climb_o, out_path_o}));

  // R9
  last_reopens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && (out_last_o || out_plan_o) |=> req_ready_o);

  // R5
  no_up_after_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_up_o && !out_plan_o && !out_last_o |=> !out_up_o);

  // R4
  path_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_path_o >> out_climb_o) == '0);
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
  parameter int ADDR_W = 6,
  localparam int LW    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_src_i,
  input  logic [ADDR_W-1:0] req_dst_i,
  input  logic              req_step_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_plan_o,
  output logic [LW-1:0]     out_climb_o,
  output logic [LW:0]       out_hops_o,
  output logic [ADDR_W-1:0] out_path_o,
  output logic              out_up_o,
  output logic              out_right_o,
  output logic              out_last_o
);
  logic [LW-1:0]     climb;
  logic [ADDR_W-1:0] path;

  tre_planner #(.ADDR_W(ADDR_W)) u_plan (
    .src_i   (req_src_i),
    .dst_i   (req_dst_i),
    .climb_o (climb),
    .path_o  (path)
  );

  tre_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_step_i  (req_step_i),
    .climb_i     (climb),
    .path_i      (path),
    .req_ready_o (req_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_plan_o  (out_plan_o),
    .out_climb_o (out_climb_o),
    .out_hops_o  (out_hops_o),
    .out_path_o  (out_path_o),
    .out_up_o    (out_up_o),
    .out_right_o (out_right_o),
    .out_last_o  (out_last_o)
  );
endmodule

// File: tb/sim_tree_route_unit.sv
module sim_tree_route_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LW = $clog2(AW + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_step = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic req_ready, out_valid, out_plan, out_up, out_right, out_last;
  logic [LW-1:0] out_climb;
  logic [LW:0]   out_hops;
  logic [AW-1:0] out_path;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_route_unit #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_src_i(req_src), .req_dst_i(req_dst), .req_step_i(req_step),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_plan_o(out_plan),
    .out_climb_o(out_climb), .out_hops_o(out_hops), .out_path_o(out_path),
    .out_up_o(out_up), .out_right_o(out_right), .out_last_o(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_climb(input int s, input int d);
    int c = 0;
    for (int i = 0; i < AW; i++) if (((s ^ d) >> i) & 1) c = i + 1;
    return c;
  endfunction

  // Waits for one beat to be taken; checks hold while stalled.
  task automatic get_beat(output logic [AW+LW+3:0] beat);
    logic [AW+LW+3:0] held;
    bit stalled = 0;
    forever begin
      if (out_valid) begin
        chk(!req_ready, "R9", req_ready, 0);
        if (stalled) chk(held == {out_plan, out_up, out_right, out_last, out_climb, out_path},
                         "R8", int'(out_path), int'(held[AW-1:0]));
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (out_valid) begin
        held = {out_plan, out_up, out_right, out_last, out_climb, out_path};
        if (out_ready) begin
          beat = held;
          @(negedge clk);
          out_ready = 1'b0;
          return;
        end
        stalled = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input int s, input int d, input bit step);
    logic [AW+LW+3:0] b;
    int c, node, lvl, maxlvl;
    c = exp_climb(s, d);
    @(negedge clk);
    req_valid = 1'b1; req_src = AW'(s); req_dst = AW'(d); req_step = step;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!step) begin
      get_beat(b);
      chk(b[AW+LW+3] == 1'b1, "R10", b[AW+LW+3], 1);
      chk(b[AW+LW+2:AW+LW] == 3'b000, "R10", int'(b[AW+LW+2:AW+LW]), 0);
      chk(int'(b[AW+LW-1:AW]) == c, "R2", int'(b[AW+LW-1:AW]), c);
      chk(int'(b[AW-1:0]) == (d & ((1 << c) - 1)), "R4", int'(b[AW-1:0]), d & ((1 << c) - 1));
      chk(req_ready, "R9", req_ready, 1);
    end else if (c == 0) begin
      chk(req_ready && !out_valid, "R7", out_valid, 0);
    end else begin
      node = s; lvl = 0; maxlvl = 0;
      for (int k = 0; k < 2 * c; k++) begin
        get_beat(b);
        chk(b[AW+LW+3] == 1'b0, "R10", b[AW+LW+3], 0);
        chk(b[AW+LW] == (k == 2 * c - 1), "R6", b[AW+LW], int'(k == 2 * c - 1));
        if (k < c) begin
          chk(b[AW+LW+2] == 1'b1, "R5", b[AW+LW+2], 1);
          node = node >> 1; lvl++;
          if (lvl > maxlvl) maxlvl = lvl;
        end else begin
          chk(b[AW+LW+2] == 1'b0, "R6", b[AW+LW+2], 0);
          chk(b[AW+LW+1] == ((d >> (2 * c - 1 - k)) & 1), "R6", b[AW+LW+1], (d >> (2 * c - 1 - k)) & 1);
          node = (node << 1) | int'(b[AW+LW+1]); lvl--;
        end
      end
      chk(node == d && lvl == 0, "R6", node, d);
      chk(maxlvl == c && (s >> c) == (d >> c) && (s >> (c - 1)) != (d >> (c - 1)), "R5", maxlvl, c);
      chk(req_ready, "R9", req_ready, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2 + 1);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid, "R1", out_valid, 0);
    // plan-mode hop count, R3
    @(negedge clk);
    req_valid = 1'b1; req_src = 6'd9; req_dst = 6'd40; req_step = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk(out_hops == 12, "R3", int'(out_hops), 12);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    run_txn(0, 0, 0);   run_txn(0, 0, 1);
    run_txn(21, 21, 1); run_txn(0, 63, 1);
    run_txn(63, 0, 0);  run_txn(5, 4, 1);
    run_txn(5, 4, 0);   run_txn(32, 31, 1);
    for (int t = 0; t < 400; t++)
      run_txn($urandom_range(0, 63), $urandom_range(0, 63), 1'($urandom_range(0, 1)));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule